// File: doc/BRIEF.md
# Pipelined Coefficient Quantizer with Rounding

This block divides each signed transform coefficient by an unsigned quantization step and rounds the result to an integer. It sits between a transform stage and an entropy coder. Each cycle it may take one coefficient together with its own step size. The matching quantized value appears a fixed number of cycles later, and results leave in the same order the coefficients entered.

The divide is fully pipelined and uses the non-restoring method. The sign of the coefficient is split off at the front and travels in a shift register alongside the data. An unsigned non-restoring core divides the magnitude, which carries one extra fractional bit, so that the quotient has a half-unit position. At the back end the sign is applied to this quotient, and then its fractional bit decides whether the value is rounded up.

Top module: `coef_quantizer`

## Requirements
- R1: One coefficient is accepted on every clock in which `inValid` is high. `outValid` goes high exactly 13 clocks after the matching `inValid`, which is one clock per quotient bit plus one output register.
- R2: The magnitude used is |inCoef| limited to 2047. A coefficient of -2048 is therefore treated as -2047, and `outQ` never takes the value -2048.
- R3: The unsigned core produces q = floor(2*m/d), a 12-bit value, where m is the magnitude from R2 and d = inDiv (1..255). It resolves one bit per stage, adding or subtracting the step according to the sign of the partial remainder. The remainder is never output.
- R4: The sign is applied before rounding: s = -q when inCoef is negative, and s = q otherwise.
- R5: Rounding uses the half-unit bit: outQ = (s + s[0]) >>> 1. With the sign applied first, this gives results such as 15/2 -> 8, -15/2 -> -7 and -7/4 -> -1.
- R6: A zero coefficient gives zero. A result never has the opposite sign to its coefficient.
- R7: A synchronous reset clears every valid bit in flight and clears `outQ` to 0. No result for a coefficient taken before the reset ever appears.
- R8: With a step of 1, `outQ` equals `inCoef` for every coefficient except -2048.
- R9: Gaps in `inValid` do not disturb the other results. Each result depends only on its own coefficient and step, whatever pattern of bubbles surrounds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Coefficient and step are valid this cycle |
| inCoef | input | 12 | Signed coefficient |
| inDiv | input | 8 | Unsigned quantization step, 1 to 255 |
| outValid | output | 1 | `outQ` holds a new result |
| outQ | output | 12 | Signed quantized and rounded value |

## Verification
The hardest case to reach is a stream where each coefficient arrives with a different step and bubbles fall in between. Only that case shows that the sign register and the step registers stay aligned with their own data word across all thirteen stages. The bench drives a pseudo-random stream of coefficient, step and valid patterns, and compares every result in arrival order against a model written from R2 to R5. Separate directed vectors cover the negative rounding cases, the saturated -2048 case, steps of 1 and 255, and a reset raised while results are still inside the pipeline.

// File: rtl/qnt_pkg.sv
package qnt_pkg;

  // Strobes that the control half hands to the datapath for the back end.
  typedef struct packed {
    logic outLoad;   // final stage holds a live word this cycle
    logic applyNeg;  // sign that belongs to that word
  } qntStrobes_t;

endpackage

// File: rtl/qnt_ctrl.sv
module qnt_ctrl
  import qnt_pkg::*;
#(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSign,
  output logic [STAGES-1:0] stageEn,
  output qntStrobes_t       strobes,
  output logic              outValid
);

  logic [STAGES:0]   validPipe;
  logic [STAGES-1:0] signPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
      signPipe  <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-1:0], inValid};
      signPipe  <= {signPipe[STAGES-2:0], inSign};
    end
  end

  // Stage i captures on the cycle its predecessor holds a live word.
  assign stageEn          = {validPipe[STAGES-2:0], inValid};
  assign strobes.outLoad  = validPipe[STAGES-1];
  assign strobes.applyNeg = signPipe[STAGES-1];
  assign outValid         = validPipe[STAGES];

endmodule

// File: rtl/qnt_datapath.sv
module qnt_datapath
  import qnt_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [COEF_W-1:0]        inCoef,
  input  logic [DIV_W-1:0]         inDiv,
  input  logic [COEF_W-1:0]        stageEn,
  input  qntStrobes_t              strobes,
  output logic signed [COEF_W-1:0] outQ
);

  localparam int MAG_W  = COEF_W - 1;
  localparam int QUO_W  = COEF_W;
  localparam int STAGES = QUO_W;
  localparam int REM_W  = DIV_W + 3;

  // Front end: saturated magnitude with one fractional zero bit below it.
  logic [COEF_W-1:0] negCoef;
  logic [MAG_W-1:0]  magVal;
  logic              isMin;

  always_comb begin
    negCoef = -inCoef;
    isMin   = inCoef[COEF_W-1] && (inCoef[COEF_W-2:0] == '0);
    if (isMin)                    magVal = '1;
    else if (inCoef[COEF_W-1])    magVal = negCoef[MAG_W-1:0];
    else                          magVal = inCoef[MAG_W-1:0];
  end

  logic signed [REM_W-1:0] remArr [STAGES];
  logic [DIV_W-1:0]        divArr [STAGES];
  logic [QUO_W-1:0]        quoArr [STAGES+1];

  assign remArr[0] = '0;
  assign divArr[0] = inDiv;
  assign quoArr[0] = {magVal, 1'b0};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic signed [REM_W-1:0] shifted;
    logic signed [REM_W-1:0] divExt;
    logic                    qBit;

    assign shifted = {remArr[i][REM_W-2:0], quoArr[i][QUO_W-1]};
    assign divExt  = $signed({{(REM_W-DIV_W){1'b0}}, divArr[i]});

    if (i < STAGES - 1) begin : g_mid
      logic signed [REM_W-1:0] nextRem;
      assign nextRem = remArr[i][REM_W-1] ? (shifted + divExt) : (shifted - divExt);
      assign qBit    = ~nextRem[REM_W-1];

      always_ff @(posedge clk) begin
        if (stageEn[i]) begin
          remArr[i+1] <= nextRem;
          divArr[i+1] <= divArr[i];
        end
      end
    end else begin : g_last
      // Only the sign of the last partial remainder matters; it is then dropped.
      assign qBit = remArr[i][REM_W-1] ? (shifted >= -divExt) : (shifted >= divExt);
    end

    always_ff @(posedge clk) begin
      if (stageEn[i]) quoArr[i+1] <= {quoArr[i][QUO_W-2:0], qBit};
    end
  end

  // Back end: sign first, then round on the half-unit bit.
  logic signed [COEF_W:0]   signedQuo;
  logic signed [COEF_W-1:0] rounded;

  always_comb begin
    signedQuo = $signed({1'b0, quoArr[STAGES]});
    if (strobes.applyNeg) signedQuo = -signedQuo;
    rounded = signedQuo[COEF_W:1] + {{(COEF_W-1){1'b0}}, signedQuo[0]};
  end

  always_ff @(posedge clk) begin
    if (rst)                  outQ <= '0;
    else if (strobes.outLoad) outQ <= rounded;
  end

endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import qnt_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [COEF_W-1:0]        inCoef,
  input  logic [DIV_W-1:0]         inDiv,
  output logic                     outValid,
  output logic signed [COEF_W-1:0] outQ
);

  localparam int STAGES = COEF_W;

  logic [STAGES-1:0] stageEn;
  qntStrobes_t       strobes;

  qnt_ctrl #(.STAGES(STAGES)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inSign   (inCoef[COEF_W-1]),
    .stageEn  (stageEn),
    .strobes  (strobes),
    .outValid (outValid)
  );

  qnt_datapath #(.COEF_W(COEF_W), .DIV_W(DIV_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .inCoef  (inCoef),
    .inDiv   (inDiv),
    .stageEn (stageEn),
    .strobes (strobes),
    .outQ    (outQ)
  );

endmodule

// File: rtl/coef_quantizer_chk.sv
module coef_quantizer_chk #(
  parameter int COEF_W = 12,
  parameter int DIV_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic [COEF_W-1:0]        inCoef,
  input logic                     outValid,
  input logic signed [COEF_W-1:0] outQ
);

  localparam int LAT = COEF_W + 1;
  localparam logic [COEF_W-1:0] MIN_VAL = {1'b1, {(COEF_W-1){1'b0}}};

  logic [LAT-1:0] vSh, negSh, zeroSh;

  always_ff @(posedge clk) begin
    if (rst) begin
      vSh    <= '0;
      negSh  <= '0;
      zeroSh <= '0;
    end else begin
      vSh    <= {vSh[LAT-2:0], inValid};
      negSh  <= {negSh[LAT-2:0], inCoef[COEF_W-1]};
      zeroSh <= {zeroSh[LAT-2:0], (inCoef == '0)};
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == vSh[LAT-1]);

  a_r7_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && outQ == '0));

  a_r2_no_min_value: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outQ != MIN_VAL));

  a_r6_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
    (outValid && zeroSh[LAT-1]) |-> (outQ == '0));

  a_r6_pos_not_neg: assert property (@(posedge clk) disable iff (rst)
    (outValid && !negSh[LAT-1]) |-> !outQ[COEF_W-1]);

  a_r6_neg_not_pos: assert property (@(posedge clk) disable iff (rst)
    (outValid && negSh[LAT-1]) |-> (outQ[COEF_W-1] || outQ == '0));

endmodule

bind coef_quantizer coef_quantizer_chk #(.COEF_W(COEF_W), .DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_coef_quantizer.sv
module test_coef_quantizer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam int NSTREAM = 200;

  // coefficient, step, expected result (worked out from R2..R5)
  localparam int vCoef [NVEC] = '{100, 15, -15, 7, -7, 2047, -2048, 0, 1, 200, -2047, 1000, -1000, 127};
  localparam int vDiv  [NVEC] = '{10,  2,  2,   4, 4,  1,    1,     37, 255, 255, 255, 3,  16,    128};
  localparam int vExp  [NVEC] = '{10,  8,  -7,  2, -1, 2047, -2047, 0, 0,  1,   -8,   333, -62,   1};

  logic clk = 0;
  logic rst = 1;
  logic inValid = 0;
  logic [11:0] inCoef = '0;
  logic [7:0]  inDiv = 8'd1;
  logic outValid;
  logic signed [11:0] outQ;

  int nCmp = 0;
  int nBad = 0;
  int gotCnt = 0;
  int gotQ [1024];
  int expQ [1024];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_quantizer i_coef_quantizer (
    .clk(clk), .rst(rst), .inValid(inValid), .inCoef(inCoef),
    .inDiv(inDiv), .outValid(outValid), .outQ(outQ)
  );

  always @(negedge clk) begin
    if (outValid && gotCnt < 1024) begin
      gotQ[gotCnt] = int'(outQ);
      gotCnt = gotCnt + 1;
    end
  end

  function automatic int modelQ(int x, int d);
    int m, q, s;
    m = (x < 0) ? -x : x;
    if (m > 2047) m = 2047;
    q = (2 * m) / d;
    s = (x < 0) ? -q : q;
    return (s + (s & 1)) >>> 1;
  endfunction

  task automatic check(string req, int got, int exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(bit v, int c, int d);
    @(negedge clk);
    inValid = v;
    inCoef  = 12'(c);
    inDiv   = 8'(d);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog R1: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp + 1, nBad);
    $finish;
  end

  initial begin
    int base;
    int lat;
    int lfsr;

    // Reset state (R7)
    repeat (3) @(negedge clk);
    check("R7 reset outValid", int'(outValid), 0);
    check("R7 reset outQ", int'(outQ), 0);
    @(negedge clk);
    rst = 0;

    // Latency of a lone coefficient (R1, R8)
    drive(1, 5, 1);
    drive(0, 0, 1);
    lat = 1;
    while (!outValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R1 latency", lat, 13);
    check("R8 step one", int'(outQ), 5);
    idle(4);

    // Vector table, back to back (R2..R6, R8)
    base = gotCnt;
    for (int i = 0; i < NVEC; i++) drive(1, vCoef[i], vDiv[i]);
    idle(20);
    check("R1 table count", gotCnt - base, NVEC);
    for (int i = 0; i < NVEC; i++) begin
      case (i)
        5, 6:    check("R2/R8 saturation and unit step", gotQ[base+i], vExp[i]);
        1, 2, 4: check("R5 rounding after sign R4", gotQ[base+i], vExp[i]);
        7:       check("R6 zero coefficient", gotQ[base+i], vExp[i]);
        default: check("R3 quotient", gotQ[base+i], vExp[i]);
      endcase
    end

    // Pseudo-random stream with bubbles (R9, R3..R5)
    base = gotCnt;
    lfsr = 32'h1ace;
    for (int n = 0; n < NSTREAM; n++) begin
      int c, d;
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 32'hffff;
      c = (lfsr & 12'hfff);
      if (c >= 2048) c = c - 4096;
      d = ((lfsr >> 4) % 255) + 1;
      expQ[n] = modelQ(c, d);
      drive(1, c, d);
      if ((lfsr & 3) == 0) idle(1 + (n % 3));
    end
    idle(20);
    check("R9 stream count", gotCnt - base, NSTREAM);
    for (int n = 0; n < NSTREAM; n++) check("R9 stream value", gotQ[base+n], expQ[n]);

    // Reset while results are in flight (R7)
    base = gotCnt;
    for (int i = 0; i < 5; i++) drive(1, 300 + i, 7);
    drive(0, 0, 1);
    rst = 1;
    idle(2);
    rst = 0;
    idle(20);
    check("R7 flushed results", gotCnt - base, 0);
    check("R7 outQ after flush", int'(outQ), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule